// File: doc/BRIEF.md
# LPC Interface Low-Power Sequencer

This block moves a Low Pin Count host interface into a low-power state and back out of it. On a sleep request it waits until no bus cycle is running. It then asserts the peripheral power-down signal and the interface reset on the same clock edge, and turns off the DMA/bus-master request inputs. One clock later it parks the frame strobe low and either drives the address/data lines to zero or releases them, as a configuration bit selects.

On a wake request the interface reset is released first. The power-down signal follows a programmable number of clocks later. The request inputs are enabled again one clock after that. A separate clock-stop handshake, in the style of the PCI clock-run protocol, clears the LPC clock enable while no bus cycle is running.

Every output comes from a flop. A 2-bit status output reports the sequencer's phase.

Top module: `lpc_pwrdn_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `state_o`=0 (active), `susp_n`=1, `lreset_n`=1, `ldrq_en`=1, `frame_low`=0, `lad_drive_zero`=0 and `lpc_clk_en`=1.
- R2: `sleep_req` is taken only at an edge where `state_o`=0 and `bus_busy`=0. On that edge `state_o` becomes 1 (entering). While `bus_busy`=1, a held `sleep_req` leaves the state at 0.
- R3: The edge that enters state 1 drives `susp_n` and `lreset_n` low together and clears `ldrq_en`. No edge lowers only one of `susp_n` and `lreset_n`.
- R4: One clock after state 1, `state_o` becomes 2 (suspended) and `frame_low` rises. `lad_drive_zero` follows `lad_park_low`: 1 drives the lines to zero and 0 tri-states them. State 2 holds until a wake request arrives.
- R5: `wake_req` in state 2 moves to state 3 (exiting) on the next edge. On that edge `lreset_n` rises, `frame_low` and `lad_drive_zero` fall, and `susp_n` stays 0.
- R6: `susp_n` rises, and `state_o` returns to 0, exactly `exit_delay`+1 clocks after `lreset_n` rises. `exit_delay` is sampled when the wake request is taken.
- R7: `ldrq_en` rises exactly one clock after `susp_n` rises.
- R8: `wake_req` has no effect outside state 2. `sleep_req` has no effect outside state 0. In particular, a sleep request during state 3 does not interrupt the exit.
- R9: `lpc_clk_en` is 0 in the cycle after an edge that samples `clkrun_stop_req`=1 and `bus_busy`=0. At every other edge it is set to 1, in any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to enter low power |
| wake_req | input | 1 | Request to leave low power |
| clkrun_stop_req | input | 1 | Request to stop the bus clock |
| bus_busy | input | 1 | A bus cycle is in progress |
| lad_park_low | input | 1 | 1: drive address/data to zero while parked; 0: tri-state |
| exit_delay | input | DLY_W | Clocks (minus one) from reset release to power-down release |
| susp_n | output | 1 | Peripheral power-down, active low |
| lreset_n | output | 1 | Interface reset, active low |
| frame_low | output | 1 | Force the frame strobe low |
| lad_drive_zero | output | 1 | Drive address/data lines to zero |
| ldrq_en | output | 1 | Enable for the bus-master request inputs |
| lpc_clk_en | output | 1 | LPC clock enable |
| state_o | output | 2 | 0 active, 1 entering, 2 suspended, 3 exiting |

## Verification
The assertions assume that `bus_busy` truthfully marks a running bus cycle, because the idle-entry and clock-stop properties are judged against it. They also assume that `exit_delay` and `lad_park_low` can change at any time, since the design samples them itself.

The stimulus changes every input only at falling clock edges. It holds `bus_busy` high across some sleep and clock-stop requests, so both the blocked and the granted paths are exercised. It also sends wake and sleep pulses in states where they must be ignored.

// File: rtl/lpc_pd_pkg.sv
`timescale 1ns/1ps
package lpc_pd_pkg;
  typedef enum logic [1:0] {
    PD_ACTIVE = 2'd0,
    PD_ENTER  = 2'd1,
    PD_SUSP   = 2'd2,
    PD_EXIT   = 2'd3
  } pd_state_e;
endpackage

// File: rtl/lpc_pd_timer.sv
`timescale 1ns/1ps
module lpc_pd_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/lpc_pd_clkctl.sv
`timescale 1ns/1ps
module lpc_pd_clkctl (
  input  logic clk,
  input  logic rst,
  input  logic stop_req,
  input  logic busy,
  output logic clk_en
);
  always_ff @(posedge clk) begin
    if (rst) clk_en <= 1'b1;
    else     clk_en <= !(stop_req && !busy);
  end
endmodule

// File: rtl/lpc_pd_fsm.sv
`timescale 1ns/1ps
module lpc_pd_fsm
  import lpc_pd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_req,
  input  logic      wake_req,
  input  logic      bus_busy,
  input  logic      lad_park_low,
  input  logic      tmr_done,
  output logic      tmr_load,
  output logic      susp_n,
  output logic      lreset_n,
  output logic      frame_low,
  output logic      lad_drive_zero,
  output logic      ldrq_en,
  output pd_state_e state
);
  pd_state_e state_d;

  always_comb begin
    state_d  = state;
    tmr_load = 1'b0;
    case (state)
      PD_ACTIVE: if (sleep_req && !bus_busy) state_d = PD_ENTER;
      PD_ENTER:  state_d = PD_SUSP;
      PD_SUSP:   if (wake_req) begin
                   state_d  = PD_EXIT;
                   tmr_load = 1'b1;
                 end
      PD_EXIT:   if (tmr_done) state_d = PD_ACTIVE;
      default:   state_d = PD_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state          <= PD_ACTIVE;
      susp_n         <= 1'b1;
      lreset_n       <= 1'b1;
      frame_low      <= 1'b0;
      lad_drive_zero <= 1'b0;
      ldrq_en        <= 1'b1;
    end else begin
      state          <= state_d;
      susp_n         <= (state_d == PD_ACTIVE);
      lreset_n       <= (state_d == PD_ACTIVE) || (state_d == PD_EXIT);
      frame_low      <= (state_d == PD_SUSP);
      lad_drive_zero <= (state_d == PD_SUSP) && lad_park_low;
      ldrq_en        <= (state_d == PD_ACTIVE) && susp_n;
    end
  end
endmodule

// File: rtl/lpc_pwrdn_seq.sv
`timescale 1ns/1ps
module lpc_pwrdn_seq
  import lpc_pd_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             clkrun_stop_req,
  input  logic             bus_busy,
  input  logic             lad_park_low,
  input  logic [DLY_W-1:0] exit_delay,
  output logic             susp_n,
  output logic             lreset_n,
  output logic             frame_low,
  output logic             lad_drive_zero,
  output logic             ldrq_en,
  output logic             lpc_clk_en,
  output logic [1:0]       state_o
);
  logic      tmr_load;
  logic      tmr_done;
  pd_state_e state;

  lpc_pd_timer #(.W(DLY_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (exit_delay),
    .done     (tmr_done)
  );

  lpc_pd_fsm u_fsm (
    .clk            (clk),
    .rst            (rst),
    .sleep_req      (sleep_req),
    .wake_req       (wake_req),
    .bus_busy       (bus_busy),
    .lad_park_low   (lad_park_low),
    .tmr_done       (tmr_done),
    .tmr_load       (tmr_load),
    .susp_n         (susp_n),
    .lreset_n       (lreset_n),
    .frame_low      (frame_low),
    .lad_drive_zero (lad_drive_zero),
    .ldrq_en        (ldrq_en),
    .state          (state)
  );

  lpc_pd_clkctl u_clkctl (
    .clk      (clk),
    .rst      (rst),
    .stop_req (clkrun_stop_req),
    .busy     (bus_busy),
    .clk_en   (lpc_clk_en)
  );

  assign state_o = state;
endmodule

// File: rtl/lpc_pwrdn_seq_chk.sv
`timescale 1ns/1ps
module lpc_pwrdn_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       wake_req,
  input logic       clkrun_stop_req,
  input logic       bus_busy,
  input logic       susp_n,
  input logic       lreset_n,
  input logic       frame_low,
  input logic       ldrq_en,
  input logic       lpc_clk_en,
  input logic [1:0] state_o
);
  p_idle_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1) |-> ($past(state_o) == 2'd0 && !$past(bus_busy)));

  p_pd_with_reset_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(susp_n) |-> $fell(lreset_n));

  p_reset_with_pd_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(lreset_n) |-> $fell(susp_n));

  p_frame_parked_r4: assert property (@(posedge clk) disable iff (rst)
    frame_low |-> (!susp_n && !lreset_n));

  p_wake_only_susp_r8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && $past(state_o) != 2'd3) |->
      ($past(state_o) == 2'd2 && $past(wake_req)));

  p_reset_first_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(susp_n) |-> (lreset_n && $past(lreset_n)));

  p_ldrq_late_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ldrq_en) |-> (susp_n && $past(susp_n)));

  p_ldrq_off_r3: assert property (@(posedge clk) disable iff (rst)
    ldrq_en |-> (susp_n && lreset_n));

  p_clk_stop_r9: assert property (@(posedge clk) disable iff (rst)
    !lpc_clk_en |-> ($past(clkrun_stop_req) && !$past(bus_busy)));
endmodule

bind lpc_pwrdn_seq lpc_pwrdn_seq_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .wake_req        (wake_req),
  .clkrun_stop_req (clkrun_stop_req),
  .bus_busy        (bus_busy),
  .susp_n          (susp_n),
  .lreset_n        (lreset_n),
  .frame_low       (frame_low),
  .ldrq_en         (ldrq_en),
  .lpc_clk_en      (lpc_clk_en),
  .state_o         (state_o)
);

// File: tb/lpc_pwrdn_seq_bench.sv
`timescale 1ns/1ps
module lpc_pwrdn_seq_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 0, wake_req = 0, clkrun_stop_req = 0, bus_busy = 0, lad_park_low = 0;
  logic [DW-1:0] exit_delay = '0;
  logic susp_n, lreset_n, frame_low, lad_drive_zero, ldrq_en, lpc_clk_en;
  logic [1:0] state_o;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int t_lrst_rise = -1, t_susp_rise = -1, t_ldrq_rise = -1;
  bit prev_lrst = 1, prev_susp = 1, prev_ldrq = 1;
  bit done = 0;

  // reference model state
  int m_state = 0, m_cnt = 0;
  bit m_susp = 1, m_lrst = 1, m_frame = 0, m_lad = 0, m_ldrq = 1, m_clk = 1;

  always #5 clk = ~clk;

  lpc_pwrdn_seq #(.DLY_W(DW)) u_lpc_pwrdn_seq (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .clkrun_stop_req(clkrun_stop_req), .bus_busy(bus_busy),
    .lad_park_low(lad_park_low), .exit_delay(exit_delay),
    .susp_n(susp_n), .lreset_n(lreset_n), .frame_low(frame_low),
    .lad_drive_zero(lad_drive_zero), .ldrq_en(ldrq_en),
    .lpc_clk_en(lpc_clk_en), .state_o(state_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // behavioural reference, updated at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_state = 0; m_susp = 1; m_lrst = 1; m_frame = 0; m_lad = 0; m_ldrq = 1; m_clk = 1;
    end else begin
      m_clk = !(clkrun_stop_req && !bus_busy);
      case (m_state)
        0: if (sleep_req && !bus_busy) begin
             m_state = 1; m_susp = 0; m_lrst = 0; m_ldrq = 0;
           end else m_ldrq = m_susp;
        1: begin m_state = 2; m_frame = 1; m_lad = lad_park_low; end
        2: if (wake_req) begin
             m_state = 3; m_lrst = 1; m_frame = 0; m_lad = 0; m_cnt = int'(exit_delay);
           end else m_lad = lad_park_low;
        default: if (m_cnt == 0) begin m_state = 0; m_susp = 1; end
                 else m_cnt--;
      endcase
    end
  end

  // compare every cycle away from the rising edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2", "state_o", int'(state_o), m_state);
      chk("R3", "susp_n", int'(susp_n), int'(m_susp));
      chk("R3", "lreset_n", int'(lreset_n), int'(m_lrst));
      chk("R4", "frame_low", int'(frame_low), int'(m_frame));
      chk("R4", "lad_drive_zero", int'(lad_drive_zero), int'(m_lad));
      chk("R7", "ldrq_en", int'(ldrq_en), int'(m_ldrq));
      chk("R9", "lpc_clk_en", int'(lpc_clk_en), int'(m_clk));
    end
    if (lreset_n && !prev_lrst) t_lrst_rise = cyc;
    if (susp_n && !prev_susp) t_susp_rise = cyc;
    if (ldrq_en && !prev_ldrq) t_ldrq_rise = cyc;
    prev_lrst = lreset_n; prev_susp = susp_n; prev_ldrq = ldrq_en;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sleep_wake(input bit park, input int dly);
    lad_park_low = park;
    sleep_req = 1;
    step(1);
    sleep_req = 0;
    chk("R2", "entering", int'(state_o), 1);
    chk("R3", "susp_n with reset", int'(susp_n) + int'(lreset_n), 0);
    step(1);
    chk("R4", "parked frame", int'(frame_low), 1);
    chk("R4", "lad park", int'(lad_drive_zero), int'(park));
    step(3);
    chk("R4", "still suspended", int'(state_o), 2);
    exit_delay = DW'(dly);
    wake_req = 1;
    step(1);
    wake_req = 0;
    exit_delay = DW'(dly + 7);
    chk("R5", "lreset_n released", int'(lreset_n), 1);
    chk("R5", "susp_n held", int'(susp_n), 0);
    chk("R5", "frame released", int'(frame_low), 0);
    step(dly + 3);
    chk("R6", "exit gap", t_susp_rise - t_lrst_rise, dly + 1);
    chk("R7", "ldrq gap", t_ldrq_rise - t_susp_rise, 1);
    chk("R6", "back active", int'(state_o), 0);
  endtask

  initial begin
    step(3);
    chk("R1", "susp_n reset", int'(susp_n), 1);
    chk("R1", "lreset_n reset", int'(lreset_n), 1);
    chk("R1", "ldrq_en reset", int'(ldrq_en), 1);
    chk("R1", "state reset", int'(state_o), 0);
    rst = 0;
    step(1);
    chk("R1", "clk_en after reset", int'(lpc_clk_en), 1);
    chk("R1", "frame after reset", int'(frame_low), 0);
    // R8: wake while active is ignored
    wake_req = 1; step(2); wake_req = 0;
    chk("R8", "wake in active", int'(state_o), 0);
    // R2: busy blocks sleep
    bus_busy = 1; sleep_req = 1; step(4);
    chk("R2", "blocked by busy", int'(state_o), 0);
    bus_busy = 0; sleep_req = 0; step(1);
    sleep_wake(1'b1, 3);
    sleep_wake(1'b0, 0);
    // R8: sleep during exit is ignored
    sleep_req = 1; step(1); sleep_req = 0; step(3);
    exit_delay = 8'd5; wake_req = 1; step(1); wake_req = 0;
    sleep_req = 1; step(2);
    chk("R8", "sleep in exit", int'(state_o), 3);
    sleep_req = 0; step(10);
    chk("R8", "exit completed", int'(state_o), 0);
    // R9: clock stop handshake
    clkrun_stop_req = 1; bus_busy = 1; step(2);
    chk("R9", "busy keeps clock", int'(lpc_clk_en), 1);
    bus_busy = 0; step(1);
    chk("R9", "clock stopped", int'(lpc_clk_en), 0);
    clkrun_stop_req = 0; step(1);
    chk("R9", "clock restarted", int'(lpc_clk_en), 1);
    step(2);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    done = 1;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule